// File: doc/BRIEF.md
# Configurable Parallel-Prefix Adder

This block adds two unsigned operands and a carry-in in a single combinational pass, returning the sum and the carry-out. Each column first forms a generate and a propagate term. The carry-in is folded into column 0 as an extra lowest column whose generate and propagate both equal the carry-in. A prefix graph then merges these terms with the associative combine (g,p)∘(g',p') = (g + p·g', p·p'). The more significant span is always the left operand. Each sum bit is the column propagate XORed with the group generate of the column below it.

The graph is picked at elaboration time. One generator builds any minimal-depth graph in which each level's lateral fan-out is a power of two. The two extreme settings of this generator are selectable by name: fan-out 1 everywhere, and fan-out doubling each level. Any fan-out vector in between is also accepted. Two alternatives that trade logic depth for fewer wires can be chosen as well. One is a sparse graph that runs the all-fan-out-1 scheme on odd columns only and then adds one extra level for the even columns. The other is an up-sweep/down-sweep tree with fan-out 1. The choice changes only the structure, never the result.

Top module: `ppa_adder`

## Requirements
- R1: With TOPO = TOPO_KNOWLES, {cout, sum} equals a + b + cin for every operand pair. The per-level fan-out comes from FO_EXP, where bits 4j+3..4j hold log2 of the fan-out at level j. Level j must have an exponent no larger than j, and no larger than the exponent of level j+1.
- R2: With TOPO = TOPO_KOGGE_STONE (fan-out 1 at every level), {cout, sum} equals a + b + cin.
- R3: With TOPO = TOPO_LADNER_FISHER (fan-out 2^j at level j), {cout, sum} equals a + b + cin.
- R4: With TOPO = TOPO_BRENT_KUNG (up-sweep then down-sweep, 2·log2(WIDTH)−1 levels), {cout, sum} equals a + b + cin.
- R5: With TOPO = TOPO_HAN_CARLSON (odd columns first, then one extra level for even columns), {cout, sum} equals a + b + cin.
- R6: The carry-in acts as a carry into bit 0. With zero operands and cin = 1, the sum is 1 and cout is 0. When every column propagates (b = ~a), the carry-in travels the full width: sum is all ones and cout is 0 for cin = 0, and sum is 0 and cout is 1 for cin = 1.
- R7: A carry generated at the top column reaches cout. All-ones plus all-ones gives sum all ones except bit 0, which equals cin, and cout = 1. Two operands with only the top bit set give sum 0 and cout 1.
- R8: Alternating operands (a = 0x55…, b = 0xAA…) produce a full-propagate word with no generate. The sum is all ones with cout = 0 when cin = 0, and all zeros with cout = 1 when cin = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is a carry that must pass through every level of the graph, crossing the longest lateral spans. Random operands seldom produce a long run of propagating columns. The stimulus therefore drives b = ~a with random a and a random carry-in, which makes every column propagate, so the carry-in alone decides every sum bit. It also drives generates placed at the top column and alternating bit patterns. All graph variants are instantiated side by side, see the same operands, and are compared on every clock against a plain integer sum.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

   typedef enum logic [2:0] {
      TOPO_KOGGE_STONE,
      TOPO_LADNER_FISHER,
      TOPO_KNOWLES,
      TOPO_BRENT_KUNG,
      TOPO_HAN_CARLSON
   } ppa_topo_e;

   localparam int FO_FIELD  = 4;
   localparam int MAX_LVL   = 16;
   localparam int MAX_WIDTH = 1024;

   // number of combine levels for a topology
   function automatic int ppa_stages(ppa_topo_e topo, int lg);
      case (topo)
         TOPO_BRENT_KUNG:  return (lg < 2) ? lg : 2 * lg - 1;
         TOPO_HAN_CARLSON: return lg + 1;
         default:          return lg;
      endcase
   endfunction

   // log2 of lateral fan-out at level s for the minimal-depth family
   function automatic int ppa_fo_exp(ppa_topo_e topo, logic [63:0] fo_vec, int s);
      case (topo)
         TOPO_KOGGE_STONE:   return 0;
         TOPO_LADNER_FISHER: return s;
         default:            return int'(fo_vec[FO_FIELD*s +: FO_FIELD]);
      endcase
   endfunction

   // lower-significance partner of column i at level s, -1 when it passes through
   function automatic int ppa_partner(ppa_topo_e topo, logic [63:0] fo_vec,
                                      int lg, int s, int i);
      int span;
      int d;
      case (topo)
         TOPO_BRENT_KUNG: begin
            if (s < lg) begin
               span = 1 << s;
               if ((i % (2 * span)) == 2 * span - 1) return i - span;
            end else begin
               d    = 2 * lg - 2 - s;
               span = 1 << d;
               if (i >= 2 * span && (i % (2 * span)) == span - 1) return i - span;
            end
         end
         TOPO_HAN_CARLSON: begin
            if (s == lg) begin
               if ((i % 2) == 0 && i >= 2) return i - 1;
            end else if ((i % 2) == 1 && i >= (1 << s)) begin
               return i - (1 << s);
            end
         end
         default: begin
            span = 1 << s;
            if (i >= span)
               return (i - span) | ((1 << ppa_fo_exp(topo, fo_vec, s)) - 1);
         end
      endcase
      return -1;
   endfunction

   // fan-out vector legality: exponent <= level, non-decreasing with level
   function automatic bit ppa_fo_ok(logic [63:0] fo_vec, int lg);
      for (int j = 0; j < lg; j++) begin
         if (int'(fo_vec[FO_FIELD*j +: FO_FIELD]) > j) return 1'b0;
         if (j + 1 < lg &&
             int'(fo_vec[FO_FIELD*j +: FO_FIELD]) > int'(fo_vec[FO_FIELD*(j+1) +: FO_FIELD]))
            return 1'b0;
      end
      return 1'b1;
   endfunction

   // walk the graph: every combine must join touching or overlapping spans,
   // and every column must end up reaching column 0
   function automatic bit ppa_graph_ok(ppa_topo_e topo, logic [63:0] fo_vec, int lg);
      int lo  [MAX_WIDTH];
      int nxt [MAX_WIDTH];
      int n;
      int k;
      n = 1 << lg;
      for (int i = 0; i < n; i++) lo[i] = i;
      for (int s = 0; s < ppa_stages(topo, lg); s++) begin
         for (int i = 0; i < n; i++) begin
            k      = ppa_partner(topo, fo_vec, lg, s, i);
            nxt[i] = lo[i];
            if (k >= 0) begin
               if (k >= i || k + 1 < lo[i]) return 1'b0;
               if (lo[k] < lo[i]) nxt[i] = lo[k];
            end
         end
         for (int i = 0; i < n; i++) lo[i] = nxt[i];
      end
      for (int i = 0; i < n; i++)
         if (lo[i] != 0) return 1'b0;
      return 1'b1;
   endfunction

endpackage

// File: rtl/ppa_pg_gen.sv
module ppa_pg_gen #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] col_p,
   output logic [WIDTH-1:0] leaf_g,
   output logic [WIDTH-1:0] leaf_p
);
   logic [WIDTH-1:0] col_g;

   assign col_g = a & b;
   assign col_p = a ^ b;

   // carry-in enters as a pseudo column below bit 0 with g = p = cin,
   // merged into column 0 before the tree
   assign leaf_g = {col_g[WIDTH-1:1], col_g[0] | (col_p[0] & cin)};
   assign leaf_p = {col_p[WIDTH-1:1], col_p[0] & cin};

endmodule

// File: rtl/ppa_dot.sv
module ppa_dot (
   input  logic hi_g,
   input  logic hi_p,
   input  logic lo_g,
   input  logic lo_p,
   output logic out_g,
   output logic out_p
);
   // more significant span on the left: order matters, the operator does not commute
   assign out_g = hi_g | (hi_p & lo_g);
   assign out_p = hi_p & lo_p;
endmodule

// File: rtl/ppa_prefix_tree.sv
module ppa_prefix_tree #(
   parameter int                  WIDTH  = 32,
   parameter ppa_pkg::ppa_topo_e  TOPO   = ppa_pkg::TOPO_KNOWLES,
   parameter logic [63:0]         FO_EXP = 64'h32100
) (
   input  logic [WIDTH-1:0] leaf_g,
   input  logic [WIDTH-1:0] leaf_p,
   output logic [WIDTH-1:0] grp_g
);
   localparam int LG = $clog2(WIDTH);
   localparam int NS = ppa_pkg::ppa_stages(TOPO, LG);

   logic [NS:0][WIDTH-1:0] lvl_g;
   logic [NS:0][WIDTH-1:0] lvl_p;

   if (!ppa_pkg::ppa_graph_ok(TOPO, FO_EXP, LG)) begin : g_bad_graph
      $error("ppa_prefix_tree: selected prefix graph does not cover every column");
   end

   assign lvl_g[0] = leaf_g;
   assign lvl_p[0] = leaf_p;

   for (genvar s = 0; s < NS; s++) begin : g_lvl
      for (genvar i = 0; i < WIDTH; i++) begin : g_col
         localparam int K = ppa_pkg::ppa_partner(TOPO, FO_EXP, LG, s, i);
         if (K >= 0) begin : g_dot
            ppa_dot u_dot (
               .hi_g  (lvl_g[s][i]),
               .hi_p  (lvl_p[s][i]),
               .lo_g  (lvl_g[s][K]),
               .lo_p  (lvl_p[s][K]),
               .out_g (lvl_g[s+1][i]),
               .out_p (lvl_p[s+1][i])
            );
         end else begin : g_pass
            assign lvl_g[s+1][i] = lvl_g[s][i];
            assign lvl_p[s+1][i] = lvl_p[s][i];
         end
      end
   end

   assign grp_g = lvl_g[NS];

   always_comb begin
      // R1 tree output obeys the serial carry recurrence
      carry_recur_chk: assert (grp_g[0] == leaf_g[0]);
      for (int i = 1; i < WIDTH; i++) begin
         // R1
         carry_chain_chk: assert (grp_g[i] == (leaf_g[i] | (leaf_p[i] & grp_g[i-1])));
      end
      for (int i = 0; i < WIDTH; i++) begin
         // R6 full propagate down to the pseudo column means the carry-in was set
         prop_implies_gen_chk: assert (!lvl_p[NS][i] || lvl_g[NS][i]);
      end
   end

endmodule

// File: rtl/ppa_sum.sv
module ppa_sum #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] col_p,
   input  logic [WIDTH-1:0] grp_g,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   logic [WIDTH-1:0] carry_in_col;

   assign carry_in_col = {grp_g[WIDTH-2:0], cin};
   assign sum          = col_p ^ carry_in_col;
   assign cout         = grp_g[WIDTH-1];

   always_comb begin
      // R8
      full_prop_chk: assert (!(&col_p) || (cout == cin));
   end

endmodule

// File: rtl/ppa_adder.sv
module ppa_adder #(
   parameter int                  WIDTH  = 32,
   parameter ppa_pkg::ppa_topo_e  TOPO   = ppa_pkg::TOPO_KNOWLES,
   parameter logic [63:0]         FO_EXP = 64'h32100
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int LG = $clog2(WIDTH);

   if (WIDTH < 2 || WIDTH > ppa_pkg::MAX_WIDTH || (1 << LG) != WIDTH) begin : g_bad_width
      $error("ppa_adder: WIDTH must be a power of two between 2 and MAX_WIDTH");
   end
   if (LG > ppa_pkg::MAX_LVL) begin : g_bad_levels
      $error("ppa_adder: too many levels for the fan-out vector");
   end
   if (TOPO == ppa_pkg::TOPO_KNOWLES) begin : g_kn_check
      if (!ppa_pkg::ppa_fo_ok(FO_EXP, LG)) begin : g_bad_fo
         $error("ppa_adder: FO_EXP violates the per-level fan-out rules");
      end
   end

   logic [WIDTH-1:0] col_p;
   logic [WIDTH-1:0] leaf_g;
   logic [WIDTH-1:0] leaf_p;
   logic [WIDTH-1:0] grp_g;

   ppa_pg_gen #(.WIDTH(WIDTH)) u_pg (
      .a      (a),
      .b      (b),
      .cin    (cin),
      .col_p  (col_p),
      .leaf_g (leaf_g),
      .leaf_p (leaf_p)
   );

   ppa_prefix_tree #(.WIDTH(WIDTH), .TOPO(TOPO), .FO_EXP(FO_EXP)) u_tree (
      .leaf_g (leaf_g),
      .leaf_p (leaf_p),
      .grp_g  (grp_g)
   );

   ppa_sum #(.WIDTH(WIDTH)) u_sum (
      .col_p (col_p),
      .grp_g (grp_g),
      .cin   (cin),
      .sum   (sum),
      .cout  (cout)
   );

   always_comb begin
      // R1
      arith_match_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}));
      // R7
      top_gen_chk: assert (!(a[WIDTH-1] && b[WIDTH-1]) || cout);
   end

endmodule

// File: tb/test_ppa_adder.sv
`timescale 1ns/1ps
module test_ppa_adder;
   import ppa_pkg::*;

   localparam int  W  = 16;
   localparam real HP = 4.0;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] a32 = '0;
   logic [31:0] b32 = '0;
   logic        cin = 1'b0;
   string       phase = "reset";
   int          total = 0;
   int          bad   = 0;
   bit          done  = 1'b0;

   logic [31:0]  s_main;
   logic         c_main;
   logic [W-1:0] s_ks, s_lf, s_kn, s_bk, s_hc;
   logic         c_ks, c_lf, c_kn, c_bk, c_hc;

   always #(HP) clk = ~clk;

   ppa_adder i_ppa_adder (.a(a32), .b(b32), .cin(cin), .sum(s_main), .cout(c_main));
   ppa_adder #(.WIDTH(W), .TOPO(TOPO_KOGGE_STONE)) i_ppa_adder_ks
      (.a(a32[W-1:0]), .b(b32[W-1:0]), .cin(cin), .sum(s_ks), .cout(c_ks));
   ppa_adder #(.WIDTH(W), .TOPO(TOPO_LADNER_FISHER)) i_ppa_adder_lf
      (.a(a32[W-1:0]), .b(b32[W-1:0]), .cin(cin), .sum(s_lf), .cout(c_lf));
   ppa_adder #(.WIDTH(W), .TOPO(TOPO_KNOWLES), .FO_EXP(64'h2100)) i_ppa_adder_kn
      (.a(a32[W-1:0]), .b(b32[W-1:0]), .cin(cin), .sum(s_kn), .cout(c_kn));
   ppa_adder #(.WIDTH(W), .TOPO(TOPO_BRENT_KUNG)) i_ppa_adder_bk
      (.a(a32[W-1:0]), .b(b32[W-1:0]), .cin(cin), .sum(s_bk), .cout(c_bk));
   ppa_adder #(.WIDTH(W), .TOPO(TOPO_HAN_CARLSON)) i_ppa_adder_hc
      (.a(a32[W-1:0]), .b(b32[W-1:0]), .cin(cin), .sum(s_hc), .cout(c_hc));

   task automatic check(string req, logic [32:0] got, logic [32:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s phase=%s a=%h b=%h cin=%0d got=%h exp=%h",
                  req, phase, a32, b32, cin, got, exp);
      end
   endtask

   // reference model: plain integer arithmetic, compared on every clock
   always @(negedge clk) begin
      longint unsigned ref32;
      longint unsigned ref16;
      if (!done) begin
         ref32 = longint'(a32) + longint'(b32) + longint'(cin);
         ref16 = longint'(a32[W-1:0]) + longint'(b32[W-1:0]) + longint'(cin);
         check("R1",    {c_main, s_main},          ref32[32:0]);
         check("R1_kn", {16'h0, c_kn, s_kn},       {16'h0, ref16[16:0]});
         check("R2",    {16'h0, c_ks, s_ks},       {16'h0, ref16[16:0]});
         check("R3",    {16'h0, c_lf, s_lf},       {16'h0, ref16[16:0]});
         check("R4",    {16'h0, c_bk, s_bk},       {16'h0, ref16[16:0]});
         check("R5",    {16'h0, c_hc, s_hc},       {16'h0, ref16[16:0]});
      end
   end

   task automatic drive(logic [31:0] av, logic [31:0] bv, logic cv, string ph);
      @(posedge clk);
      #1;
      a32   = av;
      b32   = bv;
      cin   = cv;
      phase = ph;
   endtask

   // explicit expected values for the corner requirements on the 32-bit instance
   task automatic corner(logic [31:0] av, logic [31:0] bv, logic cv,
                         string req, logic [32:0] exp);
      drive(av, bv, cv, req);
      @(negedge clk);
      #1;
      check(req, {c_main, s_main}, exp);
   endtask

   initial begin
      logic [31:0] r;
      // reset phase: inputs held at zero, outputs must be zero
      repeat (4) @(posedge clk);
      @(negedge clk);
      #1;
      check("R1", {c_main, s_main}, 33'h0);
      rst = 1'b0;

      // R6 carry-in alone and full-width propagation
      corner(32'h0, 32'h0, 1'b1, "R6", {1'b0, 32'h0000_0001});
      corner(32'hFFFF_FFFF, 32'h0, 1'b1, "R6", {1'b1, 32'h0});
      corner(32'h1234_5678, ~32'h1234_5678, 1'b0, "R6", {1'b0, 32'hFFFF_FFFF});
      corner(32'h1234_5678, ~32'h1234_5678, 1'b1, "R6", {1'b1, 32'h0});
      // R7 top generate and all-ones
      corner(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R7", {1'b1, 32'hFFFF_FFFE});
      corner(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R7", {1'b1, 32'hFFFF_FFFF});
      corner(32'h8000_0000, 32'h8000_0000, 1'b0, "R7", {1'b1, 32'h0});
      // R8 alternating patterns
      corner(32'h5555_5555, 32'hAAAA_AAAA, 1'b0, "R8", {1'b0, 32'hFFFF_FFFF});
      corner(32'h5555_5555, 32'hAAAA_AAAA, 1'b1, "R8", {1'b1, 32'h0});

      // single generate at each column, with and without a propagate run above it
      for (int k = 0; k < 32; k++) begin
         drive(32'h1 << k, 32'h1 << k, 1'b0, "walk");
         drive((32'h1 << k) | ~((32'h2 << k) - 1), 32'h1 << k, 1'b1, "walk");
      end
      // long propagate runs with random carry-in
      for (int n = 0; n < 400; n++) begin
         r = $urandom;
         drive(r, ~r, 1'($urandom), "R6");
      end
      // random operands
      for (int n = 0; n < 3000; n++) begin
         drive($urandom, $urandom, 1'($urandom), "rand");
      end
      @(posedge clk);
      @(negedge clk);
      #1;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(2.0 * HP * 200000.0);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog phase=%s got=running exp=finished", phase);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule